// File: doc/BRIEF.md
# Multi-Link Event Builder with Fragment Scoreboard

This block collects event fragments from a set of front-end readout links (sixteen by default) and merges them into one event per trigger on a single byte stream. Each link presents bytes with a valid strobe and an end-of-fragment strobe on the final byte. Each link writes into a FIFO of its own. A trigger pulse queues one event. For every queued event, a scoreboard walks the links in ascending order. It drains one fragment from each enabled link and compares the identifier carried in the first byte of each fragment with the event number it expects. Every problem it finds is recorded in a per-link error mask.

An event on the output has three parts: a header byte that carries the event identifier, the fragments of the enabled links, and a trailer that carries the error mask. A link that is marked defective is cleared in the enable mask. From then on it stores nothing and the scoreboard skips it. A SYNC pulse returns the block to a known state: the pending events are dropped, the FIFOs are emptied and the event numbering starts again from zero. The output uses a valid/ready handshake, and the sink may stall it on any cycle.

Top module: `frag_event_builder`

## Requirements
- R1: The first byte of every event is a header whose upper four bits are 4'hA and whose lower four bits are the event identifier. The identifier is the count, modulo 16, of events completed since reset or the last SYNC.
- R2: The header is followed by the fragment of each enabled link in ascending link order. Every byte is passed through unchanged. A fragment ends with the byte on which that link's end strobe was high.
- R3: While a link's enable bit is low, bytes on that link are not stored. The link contributes no bytes and its error bit is 0.
- R4: The low four bits of a fragment's first byte must equal the event identifier. If they differ, the link's error bit is set and the fragment is still forwarded.
- R5: If an enabled link's FIFO is empty and at least the programmed limit of cycles has passed since the event began, the link is closed, its error bit is set and assembly moves on.
- R6: If a fragment is longer than the free FIFO space, bytes are stored until one slot remains. The byte written into that last slot ends the fragment. The rest of the fragment is dropped and the link's error bit is set.
- R7: After the fragments, a trailer of ceil(links/8) bytes carries the error mask, low byte first, with bit n belonging to link n. The last-byte flag is high on the final trailer byte only.
- R8: While valid is high and ready is low, the output byte and the last flag hold steady. No byte is lost or repeated.
- R9: Triggers that arrive while an event is in progress are queued. Events are emitted one after another, in trigger order, and an event starts only after a trigger.
- R10: A SYNC pulse drops valid on the next cycle and clears the pending triggers and every link FIFO. The next event carries identifier 0.
- R11: After reset, the output valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | SYNC fast command pulse |
| trig_i | input | 1 | Trigger fast command pulse |
| link_en_i | input | N_LINKS | Per-link enable, low for a defective link |
| tmo_limit_i | input | TMO_W | Timeout in cycles from event start |
| lnk_data_i | input | 8*N_LINKS | Per-link data bytes, link n at bits 8n+7:8n |
| lnk_vld_i | input | N_LINKS | Per-link byte valid |
| lnk_eoe_i | input | N_LINKS | Per-link end-of-fragment strobe |
| out_data_o | output | 8 | Output byte |
| out_last_o | output | 1 | Final byte of an event |
| out_vld_o | output | 1 | Output byte valid |
| out_rdy_i | input | 1 | Sink ready |

## Verification
A scoreboard that lost its place, such as a wrong link cursor, a stale first-byte flag or an event counter that was not advanced, shows up at once in the event's bytes. Fragments come out in the wrong order, the header carries the wrong identifier, or the trailer mask does not match the links that were actually bad. A FIFO pointer fault leaves stale bytes behind, and these appear in the next event, where a disabled or freshly enabled link contributes data it should not. A fault in the pending-trigger count is seen within one event time: the stream either stays silent or starts an event that no trigger asked for.

// File: rtl/feb_pkg.sv
package feb_pkg;
   typedef enum logic [1:0] {
      AS_IDLE,
      AS_HEAD,
      AS_FRAG,
      AS_TRAIL
   } asm_state_t;

   localparam logic [7:0] HDR_MARK = 8'hA0;
endpackage

// File: rtl/feb_link_fifo.sv
module feb_link_fifo #(
   parameter int DEPTH = 8,
   parameter int DW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush_i,
   input  logic          en_i,
   input  logic          wr_vld_i,
   input  logic          wr_eoe_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic          pop_i,
   output logic [DW-1:0] rd_data_o,
   output logic          rd_eoe_o,
   output logic          empty_o,
   output logic          ovf_o,
   input  logic          ovf_clr_i
);
   localparam int AW = $clog2(DEPTH);

   logic [DW:0] mem [DEPTH];
   logic [AW:0] wptr, rptr, cnt;
   logic        drop, full, near, accept, trunc;

   assign cnt     = wptr - rptr;
   assign empty_o = (cnt == '0);
   assign full    = (cnt == (AW+1)'(DEPTH));
   assign near    = (cnt == (AW+1)'(DEPTH - 1));
   assign accept  = wr_vld_i && en_i && !drop && !full;
   assign trunc   = near && !wr_eoe_i;

   assign {rd_eoe_o, rd_data_o} = mem[rptr[AW-1:0]];

   always_ff @(posedge clk) begin
      if (accept) mem[wptr[AW-1:0]] <= {wr_eoe_i | trunc, wr_data_i};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         drop  <= 1'b0;
         ovf_o <= 1'b0;
      end else if (flush_i) begin
         wptr  <= '0;
         rptr  <= '0;
         drop  <= 1'b0;
         ovf_o <= 1'b0;
      end else begin
         if (pop_i && !empty_o) rptr <= rptr + 1'b1;
         if (ovf_clr_i) ovf_o <= 1'b0;
         if (wr_vld_i && en_i) begin
            if (drop) begin
               if (wr_eoe_i) drop <= 1'b0;
            end else if (full) begin
               ovf_o <= 1'b1;
               drop  <= !wr_eoe_i;
            end else begin
               wptr <= wptr + 1'b1;
               if (trunc) begin
                  ovf_o <= 1'b1;
                  drop  <= 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/feb_assembler.sv
module feb_assembler
   import feb_pkg::*;
#(
   parameter int N_LINKS = 16,
   parameter int ID_W    = 4,
   parameter int TMO_W   = 16,
   parameter int PEND_W  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sync_i,
   input  logic                 trig_i,
   input  logic [N_LINKS-1:0]   link_en_i,
   input  logic [TMO_W-1:0]     tmo_limit_i,
   input  logic [8*N_LINKS-1:0] rd_data_i,
   input  logic [N_LINKS-1:0]   rd_eoe_i,
   input  logic [N_LINKS-1:0]   empty_i,
   input  logic [N_LINKS-1:0]   ovf_i,
   output logic [N_LINKS-1:0]   pop_o,
   output logic [N_LINKS-1:0]   ovf_clr_o,
   output logic [7:0]           out_data_o,
   output logic                 out_last_o,
   output logic                 out_vld_o,
   input  logic                 out_rdy_i
);
   localparam int LW        = (N_LINKS > 1) ? $clog2(N_LINKS) : 1;
   localparam int TRL_BYTES = (N_LINKS + 7) / 8;
   localparam int TB_W      = (TRL_BYTES > 1) ? $clog2(TRL_BYTES) : 1;
   localparam logic [7:0] ID_MASK = 8'((1 << ID_W) - 1);

   asm_state_t              st;
   logic [LW-1:0]           cur;
   logic [TB_W-1:0]         tb;
   logic                    first;
   logic [ID_W-1:0]         evt_id;
   logic [PEND_W-1:0]       pend;
   logic [TMO_W-1:0]        timer;
   logic [N_LINKS-1:0]      err;
   logic [8*TRL_BYTES-1:0]  err_pad;

   logic [7:0] cur_byte, hdr_byte;
   logic       cur_eoe, cur_empty, cur_en, cur_ovf;
   logic       can_load, tmo_hit, take, adv, mism, evt_done;

   always_comb begin
      cur_byte  = rd_data_i[{cur, 3'b000} +: 8];
      cur_eoe   = rd_eoe_i[cur];
      cur_empty = empty_i[cur];
      cur_en    = link_en_i[cur];
      cur_ovf   = ovf_i[cur];
      can_load  = !out_vld_o || out_rdy_i;
      tmo_hit   = (timer >= tmo_limit_i);
      take      = (st == AS_FRAG) && cur_en && !cur_empty && can_load;
      adv       = (st == AS_FRAG) &&
                  (!cur_en || (take && cur_eoe) || (cur_empty && tmo_hit));
      mism      = take && first && (cur_byte[ID_W-1:0] != evt_id);
      evt_done  = (st == AS_TRAIL) && can_load && (tb == TB_W'(TRL_BYTES - 1));
      hdr_byte  = (HDR_MARK & ~ID_MASK) | {{(8-ID_W){1'b0}}, evt_id};
      pop_o          = '0;
      pop_o[cur]     = take;
      ovf_clr_o      = '0;
      ovf_clr_o[cur] = adv && cur_en;
      err_pad                = '0;
      err_pad[N_LINKS-1:0]   = err;
   end

   // pending trigger count
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= '0;
      end else if (sync_i) begin
         pend <= '0;
      end else if (trig_i && !evt_done) begin
         if (pend != '1) pend <= pend + 1'b1;
      end else if (!trig_i && evt_done) begin
         pend <= pend - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= AS_IDLE;
         cur        <= '0;
         tb         <= '0;
         first      <= 1'b0;
         evt_id     <= '0;
         timer      <= '0;
         err        <= '0;
         out_data_o <= '0;
         out_last_o <= 1'b0;
         out_vld_o  <= 1'b0;
      end else if (sync_i) begin
         st         <= AS_IDLE;
         cur        <= '0;
         tb         <= '0;
         first      <= 1'b0;
         evt_id     <= '0;
         timer      <= '0;
         err        <= '0;
         out_last_o <= 1'b0;
         out_vld_o  <= 1'b0;
      end else begin
         if (out_rdy_i) out_vld_o <= 1'b0;
         if (st != AS_IDLE && timer != '1) timer <= timer + 1'b1;
         unique case (st)
            AS_IDLE: begin
               if (pend != '0) begin
                  st    <= AS_HEAD;
                  timer <= '0;
                  err   <= '0;
                  cur   <= '0;
                  first <= 1'b1;
               end
            end
            AS_HEAD: begin
               if (can_load) begin
                  out_data_o <= hdr_byte;
                  out_last_o <= 1'b0;
                  out_vld_o  <= 1'b1;
                  st         <= AS_FRAG;
               end
            end
            AS_FRAG: begin
               if (take) begin
                  out_data_o <= cur_byte;
                  out_last_o <= 1'b0;
                  out_vld_o  <= 1'b1;
                  first      <= 1'b0;
               end
               if (cur_en && (mism || (adv && (cur_ovf || (cur_empty && tmo_hit)))))
                  err[cur] <= 1'b1;
               if (adv) begin
                  first <= 1'b1;
                  if (cur == LW'(N_LINKS - 1)) begin
                     st <= AS_TRAIL;
                     tb <= '0;
                  end else begin
                     cur <= cur + 1'b1;
                  end
               end
            end
            AS_TRAIL: begin
               if (can_load) begin
                  out_data_o <= err_pad[{tb, 3'b000} +: 8];
                  out_vld_o  <= 1'b1;
                  out_last_o <= evt_done;
                  if (evt_done) begin
                     st     <= AS_IDLE;
                     evt_id <= evt_id + 1'b1;
                  end else begin
                     tb <= tb + 1'b1;
                  end
               end
            end
            default: st <= AS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/frag_event_builder.sv
module frag_event_builder #(
   parameter int N_LINKS    = 16,
   parameter int FIFO_DEPTH = 8,
   parameter int ID_W       = 4,
   parameter int TMO_W      = 16,
   parameter int PEND_W     = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sync_i,
   input  logic                 trig_i,
   input  logic [N_LINKS-1:0]   link_en_i,
   input  logic [TMO_W-1:0]     tmo_limit_i,
   input  logic [8*N_LINKS-1:0] lnk_data_i,
   input  logic [N_LINKS-1:0]   lnk_vld_i,
   input  logic [N_LINKS-1:0]   lnk_eoe_i,
   output logic [7:0]           out_data_o,
   output logic                 out_last_o,
   output logic                 out_vld_o,
   input  logic                 out_rdy_i
);
   localparam int BYTE_W = 8;

   if (N_LINKS < 1) begin : g_bad_links
      $error("N_LINKS must be at least 1");
   end
   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two of at least 2");
   end
   if (ID_W < 1 || ID_W > 7) begin : g_bad_id
      $error("ID_W must lie between 1 and 7");
   end
   if (TMO_W < 1 || PEND_W < 1) begin : g_bad_cnt
      $error("TMO_W and PEND_W must be positive");
   end

   logic [BYTE_W*N_LINKS-1:0] rd_data;
   logic [N_LINKS-1:0]        rd_eoe, empty, ovf, pop, ovf_clr;

   for (genvar k = 0; k < N_LINKS; k++) begin : g_link
      feb_link_fifo #(
         .DEPTH (FIFO_DEPTH),
         .DW    (BYTE_W)
      ) i_fifo (
         .clk       (clk),
         .rst_n     (rst_n),
         .flush_i   (sync_i),
         .en_i      (link_en_i[k]),
         .wr_vld_i  (lnk_vld_i[k]),
         .wr_eoe_i  (lnk_eoe_i[k]),
         .wr_data_i (lnk_data_i[k*BYTE_W +: BYTE_W]),
         .pop_i     (pop[k]),
         .rd_data_o (rd_data[k*BYTE_W +: BYTE_W]),
         .rd_eoe_o  (rd_eoe[k]),
         .empty_o   (empty[k]),
         .ovf_o     (ovf[k]),
         .ovf_clr_i (ovf_clr[k])
      );
   end

   feb_assembler #(
      .N_LINKS (N_LINKS),
      .ID_W    (ID_W),
      .TMO_W   (TMO_W),
      .PEND_W  (PEND_W)
   ) i_asm (
      .clk         (clk),
      .rst_n       (rst_n),
      .sync_i      (sync_i),
      .trig_i      (trig_i),
      .link_en_i   (link_en_i),
      .tmo_limit_i (tmo_limit_i),
      .rd_data_i   (rd_data),
      .rd_eoe_i    (rd_eoe),
      .empty_i     (empty),
      .ovf_i       (ovf),
      .pop_o       (pop),
      .ovf_clr_o   (ovf_clr),
      .out_data_o  (out_data_o),
      .out_last_o  (out_last_o),
      .out_vld_o   (out_vld_o),
      .out_rdy_i   (out_rdy_i)
   );
endmodule

// File: rtl/frag_event_builder_chk.sv
module frag_event_builder_chk
   import feb_pkg::*;
#(
   parameter int ID_W = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       sync_i,
   input logic       trig_i,
   input logic [7:0] out_data_o,
   input logic       out_last_o,
   input logic       out_vld_o,
   input logic       out_rdy_i
);
   localparam logic [7:0] ID_MASK = 8'((1 << ID_W) - 1);

   logic       in_evt;
   logic [7:0] trig_cnt;
   logic       xfer;

   assign xfer = out_vld_o && out_rdy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_evt   <= 1'b0;
         trig_cnt <= '0;
      end else if (sync_i) begin
         in_evt   <= 1'b0;
         trig_cnt <= '0;
      end else begin
         if (xfer) in_evt <= !out_last_o;
         if (trig_i && !(xfer && out_last_o)) trig_cnt <= trig_cnt + 1'b1;
         else if (!trig_i && xfer && out_last_o && trig_cnt != '0) trig_cnt <= trig_cnt - 1'b1;
      end
   end

   AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n || sync_i)
      out_vld_o && !out_rdy_i |=> out_vld_o && $stable(out_data_o) && $stable(out_last_o)); // R8

   AST_HEADER_MARK: assert property (@(posedge clk) disable iff (!rst_n || sync_i)
      out_vld_o && !in_evt |-> (out_data_o & ~ID_MASK) == (HDR_MARK & ~ID_MASK)); // R1

   AST_HEADER_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n || sync_i)
      out_vld_o && !in_evt |-> !out_last_o); // R7

   AST_EVENT_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n || sync_i)
      out_vld_o && !in_evt |-> trig_cnt != '0); // R9

   AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      sync_i |=> !out_vld_o); // R10
endmodule

bind frag_event_builder frag_event_builder_chk #(.ID_W(ID_W)) i_chk (.*);

// File: tb/test_frag_event_builder.sv
module test_frag_event_builder;
   localparam int CLK_PERIOD = 10;
   localparam int N   = 16;
   localparam int NV  = 6;
   // {enable mask, bad-id mask, fragment length}
   localparam logic [39:0] VEC [NV] = '{
      40'hFFFF0000_01, 40'hFFFF0000_03, 40'h00F00010_02,
      40'h80018000_04, 40'h00000000_02, 40'h5A5A0A0A_01
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sync_i = 1'b0, trig_i = 1'b0;
   logic [N-1:0] link_en_i = '0;
   logic [15:0]  tmo_limit_i = 16'd500;
   logic [8*N-1:0] lnk_data_i = '0;
   logic [N-1:0] lnk_vld_i = '0, lnk_eoe_i = '0;
   logic [7:0]   out_data_o;
   logic         out_last_o, out_vld_o;
   logic         out_rdy_i = 1'b1;

   int n_chk = 0, n_fail = 0;
   logic [8:0] cap  [512];
   logic [8:0] expv [512];
   int cap_n = 0, lasts = 0, exp_n = 0, bp_ctr = 0;
   logic [3:0] exp_id = '0;

   frag_event_builder i_frag_event_builder (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   // sink: choose ready, then record what the next edge transfers
   initial begin
      forever begin
         @(negedge clk);
         bp_ctr++;
         out_rdy_i = (bp_ctr % 3) != 0;
         if (rst_n && out_vld_o && out_rdy_i && cap_n < 512) begin
            cap[cap_n] = {out_last_o, out_data_o};
            cap_n++;
            if (out_last_o) lasts++;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic clr_cap();
      @(posedge clk);
      cap_n = 0;
      lasts = 0;
   endtask

   task automatic pulse_trig();
      @(negedge clk); trig_i = 1'b1;
      @(negedge clk); trig_i = 1'b0;
   endtask

   task automatic send(input logic [15:0] who, input logic [15:0] bad,
                       input int len, input logic [3:0] id);
      for (int j = 0; j < len; j++) begin
         @(negedge clk);
         for (int k = 0; k < N; k++) begin
            lnk_vld_i[k] = who[k];
            lnk_eoe_i[k] = (j == len - 1);
            lnk_data_i[k*8 +: 8] = {4'(k), (j == 0) ? (bad[k] ? id + 4'd1 : id) : 4'(j)};
         end
      end
      @(negedge clk);
      lnk_vld_i = '0;
      lnk_eoe_i = '0;
      repeat (2) @(negedge clk);
   endtask

   function automatic void push(input logic [7:0] b, input logic last);
      expv[exp_n] = {last, b};
      exp_n++;
   endfunction

   function automatic void exp_event(input logic [15:0] en, input logic [15:0] bad,
                                     input int len, input logic [3:0] id);
      push({4'hA, id}, 1'b0);
      for (int k = 0; k < N; k++)
         if (en[k])
            for (int j = 0; j < len; j++)
               push({4'(k), (j == 0) ? (bad[k] ? id + 4'd1 : id) : 4'(j)}, 1'b0);
      push(bad[7:0] & en[7:0], 1'b0);
      push(bad[15:8] & en[15:8], 1'b1);
   endfunction

   task automatic wait_lasts(input int n);
      int g = 0;
      while (lasts < n && g < 5000) begin
         @(negedge clk);
         g++;
      end
      chk(lasts >= n, "R9", "event completion", lasts, n);
   endtask

   task automatic compare(input string body_tag, input string trl_tag);
      int bad_i = -1;
      chk(cap_n == exp_n, "R8", "byte count", cap_n, exp_n);
      chk(cap[0] == expv[0], "R1", "header", cap[0], expv[0]);
      for (int i = 1; i < exp_n - 2; i++)
         if (bad_i < 0 && cap[i] != expv[i]) bad_i = i;
      chk(bad_i < 0, body_tag, "fragment bytes",
          (bad_i < 0) ? 0 : cap[bad_i], (bad_i < 0) ? 0 : expv[bad_i]);
      chk({cap[exp_n-1], cap[exp_n-2]} == {expv[exp_n-1], expv[exp_n-2]}, trl_tag,
          "trailer", {cap[exp_n-1], cap[exp_n-2]}, {expv[exp_n-1], expv[exp_n-2]});
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_vld_o == 1'b0, "R11", "valid after reset", out_vld_o, 0);

      // table of events
      for (int v = 0; v < NV; v++) begin
         logic [15:0] en, bad;
         int len;
         en  = VEC[v][39:24];
         bad = VEC[v][23:8];
         len = int'(VEC[v][7:0]);
         link_en_i = en;
         send(16'hFFFF, bad, len, exp_id);
         exp_n = 0;
         exp_event(en, bad, len, exp_id);
         clr_cap();
         pulse_trig();
         wait_lasts(1);
         compare((en == 16'hFFFF) ? "R2" : "R3", ((bad & en) != 0) ? "R4" : "R7");
         exp_id++;
      end

      // timeout: link 1 never answers (R5)
      link_en_i = 16'h0003;
      tmo_limit_i = 16'd30;
      send(16'h0001, '0, 2, exp_id);
      exp_n = 0;
      exp_event(16'h0001, '0, 2, exp_id);
      expv[exp_n-2] = {1'b0, 8'h02};
      clr_cap();
      pulse_trig();
      wait_lasts(1);
      compare("R5", "R5");
      exp_id++;

      // overflow: 12-byte fragment into depth 8 (R6)
      link_en_i = 16'h0001;
      tmo_limit_i = 16'd500;
      send(16'h0001, '0, 12, exp_id);
      exp_n = 0;
      exp_event(16'h0001, '0, 8, exp_id);
      expv[exp_n-2] = {1'b0, 8'h01};
      clr_cap();
      pulse_trig();
      wait_lasts(1);
      compare("R6", "R6");
      exp_id++;

      // two queued triggers (R9)
      link_en_i = 16'h0003;
      send(16'h0003, '0, 2, exp_id);
      send(16'h0003, '0, 3, exp_id + 4'd1);
      exp_n = 0;
      exp_event(16'h0003, '0, 2, exp_id);
      exp_event(16'h0003, '0, 3, exp_id + 4'd1);
      clr_cap();
      pulse_trig();
      pulse_trig();
      wait_lasts(2);
      begin
         int bad_i = -1;
         for (int i = 0; i < exp_n; i++)
            if (bad_i < 0 && cap[i] != expv[i]) bad_i = i;
         chk(cap_n == exp_n && bad_i < 0, "R9", "two queued events",
             (bad_i < 0) ? cap_n : cap[bad_i], (bad_i < 0) ? exp_n : expv[bad_i]);
      end
      exp_id += 4'd2;

      // SYNC while an event waits on link 0 with stale data on link 3 (R10)
      link_en_i = 16'h0009;
      tmo_limit_i = 16'd60000;
      send(16'h0008, '0, 2, exp_id);
      clr_cap();
      pulse_trig();
      pulse_trig();
      repeat (20) @(negedge clk);
      sync_i = 1'b1;
      @(negedge clk);
      sync_i = 1'b0;
      exp_id = '0;
      clr_cap();
      repeat (30) @(negedge clk);
      chk(cap_n == 0, "R10", "no output after sync", cap_n, 0);
      tmo_limit_i = 16'd500;
      send(16'h0009, '0, 1, exp_id);
      exp_n = 0;
      exp_event(16'h0009, '0, 1, exp_id);
      clr_cap();
      pulse_trig();
      wait_lasts(1);
      chk(cap[0] == 9'h0A0, "R10", "identifier restarts at zero", cap[0], 9'h0A0);
      compare("R10", "R7");

      repeat (5) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule